// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a multicycle processor datapath that shares one ALU and one memory across the steps of each instruction. Every cycle it drives the full set of datapath control lines: memory address source, memory read and write strobes, instruction-register load, PC load and PC source, register-file write enable with its destination and write-data selects, the two ALU operand selects and a 3-bit ALU operation code. Its inputs are the 6-bit opcode and the 6-bit function field from the held instruction word, and the ALU zero flag.

All instructions pass through a fetch step and a decode step. In the fetch step the ALU adds four to the PC. In the decode step the ALU adds the shifted immediate to the new PC, so the branch target is already in the ALU output register before the opcode is known. The machine then takes a path whose length depends on the instruction: branch-equal completes in 3 cycles, R-type and store in 4, and load in 5. An unrecognised opcode returns from decode to fetch and writes nothing. The datapath must hold the opcode and function field steady from decode until the instruction ends. The block has no streaming data interface, so all of its pins are plain level signals.

Top module: `mcc_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, the outputs show the fetch step. A reset asserted in the middle of an instruction abandons that instruction at once.
- R2: Fetch drives `pc_load`=1, `mem_rd`=1, `instr_load`=1, `mem_addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant four), `alu_op`=010 (add) and `pc_src_sel`=0 (ALU result). Decode always follows fetch.
- R3: Decode drives `alu_a_sel`=0 and `alu_b_sel`=11 (sign-extended immediate shifted left by two), with `alu_op`=010. It asserts no write enable and no memory strobe.
- R4: Load is opcode 100011. Its path is fetch, decode, address (`alu_a_sel`=1, `alu_b_sel`=10 for the sign-extended immediate, add), memory read (`mem_rd`=1, `mem_addr_sel`=1) and writeback (`rf_we`=1, `rf_dst_sel`=0 for rt, `rf_wdata_sel`=1 for memory data). Fetch follows.
- R5: Store is opcode 101011. Its path is fetch, decode, address, then memory write (`mem_wr`=1, `mem_addr_sel`=1). Fetch follows.
- R6: R-type is opcode 000000. Its path is fetch, decode, execute (`alu_a_sel`=1, `alu_b_sel`=00 for register B), then writeback (`rf_we`=1, `rf_dst_sel`=1 for rd, `rf_wdata_sel`=0 for the ALU result). Fetch follows.
- R7: In the R-type execute step, `alu_op` is taken from the function field: 100000→010 add, 100010→110 subtract, 100100→000 and, 100101→001 or, 101010→111 set-on-less-than. Any other function value gives 010.
- R8: Branch-equal is opcode 000100. Its path is fetch, decode, then a completion step (`alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=110, `pc_src_sel`=1) in which `pc_load` follows `alu_zero` in the same cycle. Fetch follows.
- R9: Any other opcode returns from decode directly to fetch with no write enable or memory strobe asserted.
- R10: Every control line not listed for a step is 0, except `alu_op`, which is 010. `alu_zero` affects no output outside branch completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to fetch |
| opcode | input | 6 | Opcode field of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_load | output | 1 | PC write enable |
| pc_src_sel | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_load | output | 1 | Instruction register load |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Write register: 0 rt, 1 rd |
| rf_wdata_sel | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 3 | ALU operation code |

## Verification
A wrong state register shows up at the ports in the very next cycle, because each step has its own control pattern. A path that is too long or too short shows up when fetch does not appear exactly 3, 4 or 5 cycles after the previous fetch, or 2 cycles after it for an unknown opcode. A wrong decode of the opcode or function field shows up as a mismatch in the step after decode or in the execute step. The bench sweeps every opcode against every function value with the zero flag at both levels, so a fault that depends on the inputs can be seen within one instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int ALU_OP_W = 3;
  localparam int BSEL_W   = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MRD, ST_LDWB,
    ST_MWR, ST_REXE, ST_RWB, ST_BRC
  } mcc_state_e;

  localparam logic [ALU_OP_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_OP_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALU_OP_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_OP_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_OP_W-1:0] ALU_SLT = 3'b111;

  localparam logic [BSEL_W-1:0] B_REG   = 2'b00;
  localparam logic [BSEL_W-1:0] B_FOUR  = 2'b01;
  localparam logic [BSEL_W-1:0] B_IMM   = 2'b10;
  localparam logic [BSEL_W-1:0] B_IMMSH = 2'b11;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic                pc_load;
    logic                pc_src_sel;
    logic                mem_addr_sel;
    logic                mem_rd;
    logic                mem_wr;
    logic                instr_load;
    logic                rf_we;
    logic                rf_dst_sel;
    logic                rf_wdata_sel;
    logic                alu_a_sel;
    logic [BSEL_W-1:0]   alu_b_sel;
    logic [ALU_OP_W-1:0] alu_op;
  } mcc_ctrl_t;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100
) (
  input  mcc_state_e      cur,
  input  logic [OP_W-1:0] opcode,
  output mcc_state_e      nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
        else if (opcode == OP_RTYPE)                 nxt = ST_REXE;
        else if (opcode == OP_BEQ)                   nxt = ST_BRC;
        else                                         nxt = ST_FETCH;
      end
      ST_ADDR: begin
        if (opcode == OP_LOAD)       nxt = ST_MRD;
        else if (opcode == OP_STORE) nxt = ST_MWR;
        else                         nxt = ST_FETCH;
      end
      ST_MRD:  nxt = ST_LDWB;
      ST_REXE: nxt = ST_RWB;
      ST_LDWB, ST_MWR, ST_RWB, ST_BRC: nxt = ST_FETCH;
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_alu_fn_dec.sv
module mcc_alu_fn_dec
  import mcc_pkg::*;
(
  input  logic [FN_W-1:0]     funct,
  output logic [ALU_OP_W-1:0] op
);
  always_comb begin
    unique case (funct)
      FN_ADD:  op = ALU_ADD;
      FN_SUB:  op = ALU_SUB;
      FN_AND:  op = ALU_AND;
      FN_OR:   op = ALU_OR;
      FN_SLT:  op = ALU_SLT;
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_out_dec.sv
module mcc_out_dec
  import mcc_pkg::*;
(
  input  mcc_state_e          cur,
  input  logic                alu_zero,
  input  logic [ALU_OP_W-1:0] rtype_op,
  output mcc_ctrl_t           ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (cur)
      ST_FETCH: begin
        ctrl.pc_load    = 1'b1;
        ctrl.mem_rd     = 1'b1;
        ctrl.instr_load = 1'b1;
        ctrl.alu_b_sel  = B_FOUR;
      end
      ST_DECODE: ctrl.alu_b_sel = B_IMMSH;
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_IMM;
      end
      ST_MRD: begin
        ctrl.mem_rd       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_we        = 1'b1;
        ctrl.rf_wdata_sel = 1'b1;
      end
      ST_MWR: begin
        ctrl.mem_wr       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_REG;
        ctrl.alu_op    = rtype_op;
      end
      ST_RWB: begin
        ctrl.rf_we      = 1'b1;
        ctrl.rf_dst_sel = 1'b1;
      end
      ST_BRC: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = B_REG;
        ctrl.alu_op     = ALU_SUB;
        ctrl.pc_src_sel = 1'b1;
        ctrl.pc_load    = alu_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     opcode,
  input  logic [FN_W-1:0]     funct,
  input  logic                alu_zero,
  output logic                pc_load,
  output logic                pc_src_sel,
  output logic                mem_addr_sel,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                instr_load,
  output logic                rf_we,
  output logic                rf_dst_sel,
  output logic                rf_wdata_sel,
  output logic                alu_a_sel,
  output logic [BSEL_W-1:0]   alu_b_sel,
  output logic [ALU_OP_W-1:0] alu_op
);
  mcc_state_e          state, state_nxt;
  logic [ALU_OP_W-1:0] rtype_op;
  mcc_ctrl_t           ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nxt;
  end

  mcc_next_state #(
    .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
  ) u_nxt (
    .cur(state), .opcode(opcode), .nxt(state_nxt)
  );

  mcc_alu_fn_dec u_fn (.funct(funct), .op(rtype_op));

  mcc_out_dec u_out (
    .cur(state), .alu_zero(alu_zero), .rtype_op(rtype_op), .ctrl(ctrl)
  );

  assign pc_load      = ctrl.pc_load;
  assign pc_src_sel   = ctrl.pc_src_sel;
  assign mem_addr_sel = ctrl.mem_addr_sel;
  assign mem_rd       = ctrl.mem_rd;
  assign mem_wr       = ctrl.mem_wr;
  assign instr_load   = ctrl.instr_load;
  assign rf_we        = ctrl.rf_we;
  assign rf_dst_sel   = ctrl.rf_dst_sel;
  assign rf_wdata_sel = ctrl.rf_wdata_sel;
  assign alu_a_sel    = ctrl.alu_a_sel;
  assign alu_b_sel    = ctrl.alu_b_sel;
  assign alu_op       = ctrl.alu_op;
endmodule

// File: rtl/mcc_sequencer_chk.sv
module mcc_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_zero,
  input logic       pc_load,
  input logic       pc_src_sel,
  input logic       mem_addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       instr_load,
  input logic       rf_we,
  input logic       rf_dst_sel,
  input logic       rf_wdata_sel,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [2:0] alu_op
);
  // R1: a cycle under reset is followed by a fetch step
  a_r1_reset_to_fetch: assert property (@(posedge clk)
    !rst_n |=> instr_load);

  // R2: the instruction-register load comes with PC update and PC-based read
  a_r2_fetch_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    instr_load |-> (pc_load && mem_rd && !mem_addr_sel && alu_b_sel == 2'b01));

  // R3: the step after fetch writes nothing and forms the branch target
  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    instr_load |=> (!pc_load && !mem_rd && !mem_wr && !rf_we && !instr_load
                    && alu_b_sel == 2'b11 && alu_op == 3'b010));

  // R4: a data-side read is followed by a memory-data writeback to rt
  a_r4_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr_sel) |=> (rf_we && rf_wdata_sel && !rf_dst_sel));

  // R5: a store is preceded by an immediate address computation
  a_r5_store_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(alu_a_sel && alu_b_sel == 2'b10));

  // R6: rd writeback is preceded by a register-register ALU step
  a_r6_rtype_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_dst_sel) |-> $past(alu_a_sel && alu_b_sel == 2'b00 && !pc_src_sel));

  // R8: branch completion loads the PC exactly when the ALU reports zero
  a_r8_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src_sel |-> (pc_load == alu_zero && alu_op == 3'b110));

  // R10: at most one of the memory and register-file accesses in a cycle
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, rf_we}));

  // R10: the write-back steps are followed by fetch
  a_r10_return_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_wr || pc_src_sel) |=> instr_load);
endmodule

bind mcc_sequencer mcc_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alu_zero(alu_zero), .pc_load(pc_load),
  .pc_src_sel(pc_src_sel), .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .instr_load(instr_load), .rf_we(rf_we),
  .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel),
  .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
);

// File: tb/tb_mcc_sequencer.sv
module tb_mcc_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic       alu_zero = 1'b0;
  logic       pc_load, pc_src_sel, mem_addr_sel, mem_rd, mem_wr, instr_load;
  logic       rf_we, rf_dst_sel, rf_wdata_sel, alu_a_sel;
  logic [1:0] alu_b_sel;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mcc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .alu_zero(alu_zero), .pc_load(pc_load), .pc_src_sel(pc_src_sel),
    .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .instr_load(instr_load), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel),
    .rf_wdata_sel(rf_wdata_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  // Step codes local to the bench
  localparam int K_F = 0, K_D = 1, K_EA = 2, K_MR = 3, K_LW = 4,
                 K_MW = 5, K_RX = 6, K_RW = 7, K_BC = 8;

  function automatic logic [2:0] fn_op(input logic [5:0] f);
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  // Bundle order: pc_load pc_src addr_sel rd wr ir_ld we dst wsel a_sel b_sel[2] op[3]
  function automatic logic [14:0] expect_of(input int k, input logic [5:0] f, input logic z);
    case (k)
      K_F:  return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 3'b010};
      K_D:  return {10'b0, 2'b11, 3'b010};
      K_EA: return {9'b0, 1'b1, 2'b10, 3'b010};
      K_MR: return {2'b00, 1'b1, 1'b1, 6'b0, 2'b00, 3'b010};
      K_LW: return {6'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 3'b010};
      K_MW: return {3'b001, 1'b0, 1'b1, 5'b0, 2'b00, 3'b010};
      K_RX: return {9'b0, 1'b1, 2'b00, fn_op(f)};
      K_RW: return {6'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 3'b010};
      default: return {z, 1'b1, 7'b0, 1'b1, 2'b00, 3'b110};
    endcase
  endfunction

  task automatic check(input string tag, input int k);
    logic [14:0] act, exp;
    #1;
    act = {pc_load, pc_src_sel, mem_addr_sel, mem_rd, mem_wr, instr_load,
           rf_we, rf_dst_sel, rf_wdata_sel, alu_a_sel, alu_b_sel, alu_op};
    exp = expect_of(k, funct, alu_zero);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b fn=%b z=%b step=%0d actual=%b expected=%b",
               tag, opcode, funct, alu_zero, k, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  // Called at a negedge while the design is in fetch; leaves at the next fetch.
  task automatic run_instr(input logic [5:0] op, input logic [5:0] f, input logic z);
    opcode = op; funct = f; alu_zero = z;
    check("R2 fetch", K_F);
    next_cycle(); check("R3 decode", K_D);
    case (op)
      6'b100011: begin
        next_cycle(); check("R4 load address", K_EA);
        next_cycle(); check("R4 load read", K_MR);
        next_cycle(); check("R4 load writeback", K_LW);
      end
      6'b101011: begin
        next_cycle(); check("R5 store address", K_EA);
        next_cycle(); check("R5 store write", K_MW);
      end
      6'b000000: begin
        next_cycle(); check("R7 rtype execute", K_RX);
        next_cycle(); check("R6 rtype writeback", K_RW);
      end
      6'b000100: begin
        next_cycle(); check("R8 branch complete", K_BC);
      end
      default: ; // R9: fetch must follow decode, checked next
    endcase
    next_cycle();
    if (op == 6'b100011 || op == 6'b101011 || op == 6'b000000 || op == 6'b000100)
      check("R10 return to fetch", K_F);
    else
      check("R9 unknown opcode back to fetch", K_F);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    check("R1 fetch under reset", K_F);
    next_cycle();
    rst_n = 1'b1;
    check("R1 fetch after reset release", K_F);

    // Sweep every opcode against every function value and both zero levels
    for (int op = 0; op < 64; op++)
      for (int f = 0; f < 64; f++)
        for (int z = 0; z < 2; z++)
          run_instr(6'(op), 6'(f), 1'(z));

    // R1: reset in the middle of a load abandons it
    opcode = 6'b100011; funct = '0; alu_zero = 1'b0;
    check("R1 load fetch", K_F);
    next_cycle(); next_cycle(); next_cycle();
    check("R4 load read before reset", K_MR);
    rst_n = 1'b0;
    check("R1 mid-instruction reset", K_F);
    next_cycle();
    rst_n = 1'b1;
    check("R1 fetch after mid reset", K_F);
    next_cycle();
    check("R3 decode after mid reset", K_D);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule